// File: doc/BRIEF.md
# Chaotic On-Off Keying Modem

This block sends data bits over a chaotic carrier and recovers them again by measuring energy. On the transmit side, an incoming carrier sample stream is either passed through or replaced by zeros. It is passed through for the whole bit period of a one bit and zeroed for the whole period of a zero bit. A ready strobe marks the single cycle in each bit period where a new bit can be accepted. If no bit is offered in that cycle, the following period is silent.

On the receive side, the channel samples are squared and summed over one bit period. At the end of each period the sum is compared with a threshold. Both sides run from one shared sample counter, and one sample is taken per clock. Because the decision rests only on energy, the receiver never needs a copy of the carrier or any carrier synchronization. With a direct loopback from the channel output to the channel input, each recovered bit appears one bit period after the bit was sent, plus two cycles.

The number of samples per bit is a parameter. Its default of 10 matches a bit duration ten times the carrier integration step.

Top module: `cook_modem`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `chan_out` is 0, `bit_ready` is 0, `rx_valid` is 0 and `rx_bit` is 0.
- R2: Counting the first cycle after reset as index 0, `bit_ready` is high exactly in the cycles whose index modulo SPB equals SPB-1, and low in all others.
- R3: A bit is accepted in a cycle where `bit_ready` and `bit_valid` are both high. It governs the next SPB channel samples.
- R4: `chan_out` in cycle c+1 equals `carrier` of cycle c whenever the bit governing cycle c is 1.
- R5: If `bit_valid` is low while `bit_ready` is high, the following period transmits zeros and is decided as 0.
- R6: For each period, the energy is the unsigned sum of `chan_in` squared over the cycles with index 1..SPB-1 of that period plus index 0 of the next period. `rx_bit` is 1 only if the energy is strictly greater than `thresh`, so equality gives 0. The sum never wraps, even for full-scale negative samples.
- R7: `rx_valid` is a one-cycle pulse in the cycle with index 1 of each period. The first two boundaries after reset produce no pulse, so the first pulse belongs to the first bit accepted.
- R8: The energy sum restarts at every boundary. A full-scale period followed by a silent period decides the silent one as 0.
- R9: `thresh` is used only in the decision cycle (index 0). Its value in other cycles has no effect.
- R10: While the governing bit is 0, `chan_out` is 0 whatever the value of `carrier`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bit_data | input | 1 | Data bit to send |
| bit_valid | input | 1 | `bit_data` is offered |
| bit_ready | output | 1 | Bit acceptance cycle (last cycle of a period) |
| carrier | input | SAMPLE_W | Signed chaotic carrier sample |
| thresh | input | ENERGY_W | Unsigned decision threshold |
| chan_out | output | SAMPLE_W | Signed gated channel sample |
| chan_in | input | SAMPLE_W | Signed received channel sample |
| rx_bit | output | 1 | Recovered bit |
| rx_valid | output | 1 | `rx_bit` is new in this cycle |

## Verification
The boundary cycle carries two jobs at once. It adds the last sample of a bit into the sum, and in the same cycle it decides that bit and clears the sum for the next one. A slip in either direction moves energy between neighbouring bits. This is provoked by constant full-scale carriers with alternating bits, by carriers whose energy lands exactly on the threshold, and by a threshold that changes only in the decision cycle. Every decision is judged against an energy window the bench computes from the samples it drove, and the window results are queued in order.

// File: rtl/cook_pkg.sv
package cook_pkg;

  // Width that holds the sum of SPB squared signed samples without wrap.
  function automatic int energy_bits(int sample_w, int spb);
    return 2 * sample_w + $clog2(spb + 1);
  endfunction

  // Per-cycle timing marks shared by transmitter and receiver.
  typedef struct packed {
    logic accept;    // last cycle of a period: new bit taken
    logic boundary;  // first cycle of a period: previous bit decided
  } cook_tick_t;

endpackage

// File: rtl/cook_bit_timer.sv
module cook_bit_timer
  import cook_pkg::*;
#(
  parameter int SPB = 10,
  localparam int CNT_W = (SPB > 2) ? $clog2(SPB) : 1
) (
  input  logic       clk,
  input  logic       rst,
  output cook_tick_t tick
);

  logic [CNT_W-1:0] phase_q;
  logic             accept_q;
  logic             boundary_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= '0;
      accept_q   <= 1'b0;
      boundary_q <= 1'b0;
    end else begin
      if (phase_q == CNT_W'(SPB - 1)) phase_q <= '0;
      else                            phase_q <= phase_q + 1'b1;
      // the accept mark is registered one cycle ahead of the wrap
      accept_q   <= (phase_q == CNT_W'(SPB - 2));
      boundary_q <= accept_q;
    end
  end

  assign tick.accept   = accept_q;
  assign tick.boundary = boundary_q;

endmodule

// File: rtl/cook_gate_tx.sv
module cook_gate_tx #(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       accept,
  input  logic                       bit_valid,
  input  logic                       bit_data,
  input  logic signed [SAMPLE_W-1:0] carrier,
  output logic signed [SAMPLE_W-1:0] chan_out,
  output logic                       tx_on
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_on    <= 1'b0;
      chan_out <= '0;
    end else begin
      if (accept) tx_on <= bit_valid & bit_data;
      chan_out <= tx_on ? carrier : '0;
    end
  end

endmodule

// File: rtl/cook_energy_rx.sv
module cook_energy_rx #(
  parameter int SAMPLE_W = 16,
  parameter int ENERGY_W = 36
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       boundary,
  input  logic signed [SAMPLE_W-1:0] chan_in,
  input  logic [ENERGY_W-1:0]        thresh,
  output logic [ENERGY_W-1:0]        acc,
  output logic                       rx_bit,
  output logic                       rx_valid
);

  localparam int SQ_W = 2 * SAMPLE_W;
  localparam int PAD  = ENERGY_W - SQ_W;

  logic signed [SQ_W-1:0]   sq_s;
  logic [ENERGY_W-1:0]      sq_u;
  logic [ENERGY_W-1:0]      sum;
  logic                     live_q;

  assign sq_s = chan_in * chan_in;
  generate
    if (PAD > 0) begin : g_pad
      assign sq_u = {{PAD{1'b0}}, sq_s};
    end else begin : g_nopad
      assign sq_u = sq_s;
    end
  endgenerate
  assign sum = acc + sq_u;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      live_q   <= 1'b0;
      rx_bit   <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (boundary) begin
        acc    <= '0;
        live_q <= 1'b1;
        // the first boundary closes a window that held no accepted bit
        if (live_q) begin
          rx_bit   <= (sum > thresh);
          rx_valid <= 1'b1;
        end
      end else begin
        acc <= sum;
      end
    end
  end

endmodule

// File: rtl/cook_modem.sv
module cook_modem
  import cook_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SPB      = 10,
  localparam int ENERGY_W = energy_bits(SAMPLE_W, SPB)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bit_data,
  input  logic                       bit_valid,
  output logic                       bit_ready,
  input  logic signed [SAMPLE_W-1:0] carrier,
  input  logic [ENERGY_W-1:0]        thresh,
  output logic signed [SAMPLE_W-1:0] chan_out,
  input  logic signed [SAMPLE_W-1:0] chan_in,
  output logic                       rx_bit,
  output logic                       rx_valid
);

  cook_tick_t          tick;
  logic                tx_on;
  logic [ENERGY_W-1:0] rx_acc;

  cook_bit_timer #(.SPB(SPB)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  cook_gate_tx #(.SAMPLE_W(SAMPLE_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .accept    (tick.accept),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .carrier   (carrier),
    .chan_out  (chan_out),
    .tx_on     (tx_on)
  );

  cook_energy_rx #(.SAMPLE_W(SAMPLE_W), .ENERGY_W(ENERGY_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .boundary (tick.boundary),
    .chan_in  (chan_in),
    .thresh   (thresh),
    .acc      (rx_acc),
    .rx_bit   (rx_bit),
    .rx_valid (rx_valid)
  );

  assign bit_ready = tick.accept;

endmodule

// File: rtl/cook_modem_chk.sv
module cook_modem_chk #(
  parameter int SAMPLE_W = 16,
  parameter int SPB      = 10,
  parameter int ENERGY_W = 36
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bit_ready,
  input logic                       bit_valid,
  input logic signed [SAMPLE_W-1:0] chan_out,
  input logic                       rx_valid,
  input logic                       tx_on,
  input logic [ENERGY_W-1:0]        acc,
  input logic                       boundary
);

  int unsigned ph;

  always_ff @(posedge clk) begin
    if (rst) ph <= 0;
    else     ph <= (ph == SPB - 1) ? 0 : ph + 1;
  end

  AST_READY_CADENCE: assert property (@(posedge clk) disable iff (rst)
    bit_ready == (ph == SPB - 1)); // R2

  AST_IDLE_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (bit_ready && !bit_valid) |=> !tx_on); // R5

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    !tx_on |=> (chan_out == '0)); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> (acc >= $past(acc))); // R6

  AST_CLEAR_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    boundary |=> (acc == '0)); // R8

  AST_DECIDE_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(boundary)); // R7

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R7

endmodule

bind cook_modem cook_modem_chk #(
  .SAMPLE_W (SAMPLE_W),
  .SPB      (SPB),
  .ENERGY_W (ENERGY_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_ready (bit_ready),
  .bit_valid (bit_valid),
  .chan_out  (chan_out),
  .rx_valid  (rx_valid),
  .tx_on     (tx_on),
  .acc       (rx_acc),
  .boundary  (tick.boundary)
);

// File: tb/test_cook_modem.sv
module test_cook_modem;

  localparam int SW  = 16;
  localparam int SPB = 10;
  localparam int EW  = 2 * SW + $clog2(SPB + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic                 rst;
  logic                 bit_data, bit_valid, bit_ready;
  logic signed [SW-1:0] carrier;
  logic [EW-1:0]        thresh;
  logic signed [SW-1:0] chan_out;
  logic signed [SW-1:0] chan_in;
  logic                 rx_bit, rx_valid;

  assign chan_in = chan_out;  // direct loopback channel

  cook_modem #(.SAMPLE_W(SW), .SPB(SPB)) i_cook_modem (
    .clk (clk), .rst (rst), .bit_data (bit_data), .bit_valid (bit_valid),
    .bit_ready (bit_ready), .carrier (carrier), .thresh (thresh),
    .chan_out (chan_out), .chan_in (chan_in), .rx_bit (rx_bit), .rx_valid (rx_valid)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  bit running = 1'b0;

  // stimulus controls
  int     car_mode, bit_mode;
  longint kconst, thr_dec, thr_far;
  bit     alt;
  int     pcnt;
  string  tag;
  real    cx, cy, cz, cu;

  // bench reference state
  longint               eacc;
  int                   windows;
  logic signed [SW-1:0] exp_out;
  string                exp_tag;
  bit                   m_on;
  bit                   q[$];

  task automatic chk(bit ok, string req, longint act, longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  function automatic logic signed [SW-1:0] chaos_step();
    real dx, dy, dz, du, s;
    dx = 7.0 * cz - 7.0 * cx * (-1.2 + cu * cu);
    dy = 1.0 * (1.0 * cy - cz);
    dz = 2.5 * (cy - cx);
    du = -6.0 * cx;
    cx = cx + 0.001 * dx; cy = cy + 0.001 * dy;
    cz = cz + 0.001 * dz; cu = cu + 0.001 * du;
    s = cx * 2048.0;
    if (s > 32767.0)  s = 32767.0;
    if (s < -32768.0) s = -32768.0;
    return SW'($rtoi(s));
  endfunction

  task automatic apply();
    case (car_mode)
      0: carrier = chaos_step();
      1: carrier = SW'($urandom);
      default: carrier = SW'(kconst);
    endcase
    thresh = (pcnt == 0) ? EW'(thr_dec) : EW'(thr_far);
    case (bit_mode)
      0: begin bit_valid = 1'b1; bit_data = 1'($urandom); end
      1: begin bit_valid = ($urandom % 3) != 0; bit_data = 1'($urandom); end
      2: begin bit_valid = 1'b1; bit_data = 1'b1; end
      default: begin
        bit_valid = 1'b1; bit_data = alt;
        if (pcnt == SPB - 1) alt = ~alt;
      end
    endcase
  endtask

  task automatic run(int periods);
    for (int i = 0; i < periods * SPB; i++) begin
      @(posedge clk); #1;
      pcnt = (pcnt + 1) % SPB;
      apply();
    end
  endtask

  // reference monitor, away from the active edge
  always @(negedge clk) begin
    if (running && !done) begin
      longint v;
      v = longint'(chan_out);
      chk(chan_out == exp_out, exp_tag, v, longint'(exp_out));
      chk(bit_ready == (pcnt == SPB - 1), "R2", bit_ready, pcnt == SPB - 1);
      if (pcnt == 1) chk(rx_valid == (windows >= 3), "R7", rx_valid, windows >= 3);
      else           chk(rx_valid == 1'b0, "R7", rx_valid, 0);
      if (rx_valid) begin
        if (q.size() == 0) chk(1'b0, tag, rx_bit, -1);
        else begin
          bit e;
          e = q.pop_front();
          chk(rx_bit == e, tag, rx_bit, e);
        end
      end
      if (pcnt == 0) begin
        longint fin;
        fin = eacc + v * v;
        windows++;
        // R6/R9: strict comparison with the threshold seen in the decision cycle
        if (windows >= 3) q.push_back(fin > longint'(thresh));
        eacc = 0;
      end else begin
        eacc += v * v;
      end
      exp_tag = m_on ? "R4" : "R10";
      exp_out = m_on ? carrier : '0;
      if (bit_ready) m_on = bit_valid & bit_data;  // R3, R5
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    cx = 0.1; cy = 0.0; cz = 0.0; cu = 0.0;
    rst = 1'b1; bit_data = 0; bit_valid = 0; carrier = '0; thresh = '0;
    car_mode = 0; bit_mode = 0; kconst = 0; thr_dec = 20000; thr_far = 20000;
    alt = 1'b1; eacc = 0; windows = 0; exp_out = '0; exp_tag = "R1"; m_on = 0;
    tag = "R3";
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(chan_out == 0, "R1", chan_out, 0);
    chk(bit_ready == 0, "R1", bit_ready, 0);
    chk(rx_valid == 0, "R1", rx_valid, 0);
    chk(rx_bit == 0, "R1", rx_bit, 0);
    @(posedge clk); #1;
    rst = 1'b0; pcnt = 0; apply(); running = 1'b1;

    // R3/R4: chaotic carrier, random bits every period
    tag = "R3"; run(60);
    // R5: random carrier, idle periods, random thresholds
    car_mode = 1; bit_mode = 1; tag = "R5";
    for (int k = 0; k < 8; k++) begin
      thr_dec = longint'($urandom % 32'h4000_0000) * 4;
      thr_far = thr_dec;
      run(10);
    end
    // R6: energy exactly equal to the threshold decides 0, one below decides 1
    car_mode = 2; bit_mode = 2; kconst = 100; tag = "R6";
    thr_dec = 100000; thr_far = 100000; run(6);
    thr_dec = 99999;  thr_far = 99999;  run(6);
    // R6: zero carrier with bit 1 and zero threshold decides 0
    kconst = 0; thr_dec = 0; thr_far = 0; run(5);
    // R8: full-scale negative carrier, alternating bits, no carry-over
    kconst = -32768; bit_mode = 3; tag = "R8"; run(12);
    // R9: threshold only matters in the decision cycle
    kconst = 100; bit_mode = 2; tag = "R9";
    thr_far = 0; thr_dec = 200000; run(6);
    thr_far = 64'h0000_000F_FFFF_FFFF; thr_dec = 5; run(6);
    // flush outstanding decisions
    tag = "R3"; car_mode = 1; bit_mode = 0; thr_dec = 20000; thr_far = 20000; run(4);
    chk(q.size() <= 2, "R7", q.size(), 2);
    done = 1'b1;
    summary();
  end

endmodule